// File: doc/BRIEF.md
# Strobe Signal Port Router

This block takes a bundle of internal timing strobes and steers them onto a small set of external strobe output pins. Software sets up the routing one strobe at a time. A single 16-bit configuration write names a strobe by index, says whether that strobe is enabled, and picks the output port it should drive. The block keeps a small table with one enable and one port number per strobe. Each output port is the registered OR of every enabled strobe that is routed to it.

The configuration register can be written at any time. Writes that do not drive both byte lanes are dropped, and so are writes that name an index beyond the implemented strobes. When the single-channel input is high, the strobes that belong to the second channel (index `CHB_BASE` and up) are forced to contribute nothing. A read of the register returns the last accepted write.

Top module: `strobe_port_router`

## Requirements
- R1: While reset is active and right after it, every entry is disabled, `strobe_out` is all zero and `rd_data` is zero.
- R2: A write is accepted when `wr_en` is high and `wr_be` is 2'b11. The write takes its fields from `wr_data`: index in bits [14:8], enable in bit 4, and port number in bits [1:0]. All other bits are ignored.
- R3: An accepted write replaces the enable and port of the indexed strobe only. Every other strobe keeps its configuration.
- R4: An enabled strobe drives only the port its entry selects. It never drives more than one port.
- R5: When several enabled strobes share a port, that port carries the OR of their values.
- R6: A port with no enabled strobe routed to it outputs 0. A disabled strobe has no effect on any port.
- R7: Outputs are registered. A change on `strobe_in` before clock edge k shows on `strobe_out` after edge k. A configuration write accepted at edge k affects `strobe_out` from edge k+1.
- R8: A write whose `wr_be` is not 2'b11 changes neither the table nor `rd_data`.
- R9: A write with an index of `NUM_SIG` or higher changes neither the table nor `rd_data`.
- R10: While `single_chan` is high, strobes with index at or above `CHB_BASE` contribute 0 to every port.
- R11: `rd_data` holds the fields of the last accepted write in the R2 positions, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 2 | Byte-lane enables of the write |
| wr_data | input | 16 | Write data: index, enable, port number |
| rd_data | output | 16 | Readback of the last accepted write |
| single_chan | input | 1 | Single-channel mode; mutes second-channel strobes |
| strobe_in | input | NUM_SIG | Internal timing strobes |
| strobe_out | output | NUM_PORTS | External strobe ports |

## Verification
The bench targets several corner cases:
- Two strobes are stacked on one port. A design that muxed instead of OR-ing would lose one of them.
- A strobe is moved from one port to another. A design that cleared the old entry late, or touched a neighbouring entry, would drive two ports or drop a bystander.
- Writes with one byte lane and writes with an index just past the implemented count must leave both the ports and the readback untouched. A design that decoded only `wr_en` would let these writes through.
- Output latency is checked on both sides of the edge. A combinational path, or an extra register stage, would show the new value one cycle too early or too late.
- Single-channel muting is checked against a bench model over a sweep of patterns.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int REG_W    = 16;
    localparam int SEL_LSB  = 8;
    localparam int SEL_W    = 7;
    localparam int EN_BIT   = 4;
    localparam int PORT_LSB = 0;
    localparam int PSEL_W   = 2;

    typedef logic [PSEL_W-1:0] psel_t;

    typedef struct packed {
        logic  en;
        psel_t port;
    } route_t;
endpackage

// File: rtl/srt_cfg_table.sv
module srt_cfg_table
    import srt_pkg::*;
#(
    parameter int NUM_SIG = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_be,
    input  logic [REG_W-1:0]            wr_data,
    output logic [NUM_SIG-1:0]          en_vec,
    output logic [NUM_SIG*PSEL_W-1:0]   port_vec,
    output logic [REG_W-1:0]            rd_data
);
    logic [SEL_W-1:0] wr_sel;
    logic             wr_full;
    logic             wr_in_range;
    logic             accept;
    route_t           wr_route;
    route_t           last_route_q;
    logic [SEL_W-1:0] last_sel_q;

    assign wr_sel        = wr_data[SEL_LSB +: SEL_W];
    assign wr_route.en   = wr_data[EN_BIT];
    assign wr_route.port = wr_data[PORT_LSB +: PSEL_W];
    assign wr_full       = (wr_be == 2'b11);
    assign wr_in_range   = (32'(wr_sel) < NUM_SIG);
    assign accept        = wr_en && wr_full && wr_in_range;

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_entry
        route_t entry_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (accept && (wr_sel == SEL_W'(i))) begin
                entry_q <= wr_route;
            end
        end
        assign en_vec[i]                     = entry_q.en;
        assign port_vec[i*PSEL_W +: PSEL_W]  = entry_q.port;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sel_q   <= '0;
            last_route_q <= '0;
        end else if (accept) begin
            last_sel_q   <= wr_sel;
            last_route_q <= wr_route;
        end
    end

    always_comb begin
        rd_data                          = '0;
        rd_data[SEL_LSB +: SEL_W]        = last_sel_q;
        rd_data[EN_BIT]                  = last_route_q.en;
        rd_data[PORT_LSB +: PSEL_W]      = last_route_q.port;
    end
endmodule

// File: rtl/srt_port_mux.sv
module srt_port_mux
    import srt_pkg::*;
#(
    parameter int NUM_SIG   = 20,
    parameter int NUM_PORTS = 4,
    parameter int CHB_BASE  = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        single_chan,
    input  logic [NUM_SIG-1:0]          strobe_in,
    input  logic [NUM_SIG-1:0]          en_vec,
    input  logic [NUM_SIG*PSEL_W-1:0]   port_vec,
    output logic [NUM_PORTS-1:0]        strobe_out
);
    logic [NUM_SIG-1:0]   live;
    logic [NUM_PORTS-1:0] port_d;

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_live
        if (i >= CHB_BASE) begin : g_chb
            assign live[i] = strobe_in[i] & en_vec[i] & ~single_chan;
        end else begin : g_cha
            assign live[i] = strobe_in[i] & en_vec[i];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            port_d[p] = 1'b0;
            for (int i = 0; i < NUM_SIG; i++) begin
                if (port_vec[i*PSEL_W +: PSEL_W] == PSEL_W'(p)) begin
                    port_d[p] = port_d[p] | live[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_out <= '0;
        end else begin
            strobe_out <= port_d;
        end
    end
endmodule

// File: rtl/strobe_port_router.sv
module strobe_port_router
    import srt_pkg::*;
#(
    parameter int NUM_SIG   = 20,
    parameter int NUM_PORTS = 4,
    parameter int CHB_BASE  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_be,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    input  logic                 single_chan,
    input  logic [NUM_SIG-1:0]   strobe_in,
    output logic [NUM_PORTS-1:0] strobe_out
);
    logic [NUM_SIG-1:0]        en_vec;
    logic [NUM_SIG*PSEL_W-1:0] port_vec;

    srt_cfg_table #(
        .NUM_SIG (NUM_SIG)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .en_vec   (en_vec),
        .port_vec (port_vec),
        .rd_data  (rd_data)
    );

    srt_port_mux #(
        .NUM_SIG   (NUM_SIG),
        .NUM_PORTS (NUM_PORTS),
        .CHB_BASE  (CHB_BASE)
    ) i_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .single_chan (single_chan),
        .strobe_in   (strobe_in),
        .en_vec      (en_vec),
        .port_vec    (port_vec),
        .strobe_out  (strobe_out)
    );
endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
    parameter int NUM_SIG   = 20,
    parameter int NUM_PORTS = 4,
    parameter int CHB_BASE  = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [1:0]           wr_be,
    input logic [15:0]          wr_data,
    input logic [15:0]          rd_data,
    input logic                 single_chan,
    input logic [NUM_SIG-1:0]   strobe_in,
    input logic [NUM_PORTS-1:0] strobe_out
);
    localparam logic [NUM_SIG-1:0] LO_MASK = NUM_SIG'((64'd1 << CHB_BASE) - 64'd1);

    logic full_ok;
    assign full_ok = wr_en && (wr_be == 2'b11) && (32'(wr_data[14:8]) < NUM_SIG);

    AST_IDLE_PORTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe_in) == '0) |-> (strobe_out == '0)); // R6

    AST_NARROW_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be != 2'b11) |=> $stable(rd_data)); // R8

    AST_RANGE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b11 && 32'(wr_data[14:8]) >= NUM_SIG) |=> $stable(rd_data)); // R9

    AST_READBACK_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        full_ok |=> (rd_data == {1'b0, $past(wr_data[14:8]), 3'b000,
                                 $past(wr_data[4]), 2'b00, $past(wr_data[1:0])})); // R11

    AST_SINGLE_CHAN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(single_chan) && (($past(strobe_in) & LO_MASK) == '0)) |-> (strobe_out == '0)); // R10

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data)); // R2
endmodule

bind strobe_port_router srt_chk #(
    .NUM_SIG   (NUM_SIG),
    .NUM_PORTS (NUM_PORTS),
    .CHB_BASE  (CHB_BASE)
) i_srt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .single_chan (single_chan),
    .strobe_in   (strobe_in),
    .strobe_out  (strobe_out)
);

// File: tb/test_strobe_port_router.sv
`timescale 1ns/1ps
module test_strobe_port_router;
    localparam int NUM_SIG   = 20;
    localparam int NUM_PORTS = 4;
    localparam int CHB_BASE  = 10;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 wr_en;
    logic [1:0]           wr_be;
    logic [15:0]          wr_data;
    logic [15:0]          rd_data;
    logic                 single_chan;
    logic [NUM_SIG-1:0]   strobe_in;
    logic [NUM_PORTS-1:0] strobe_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_en [NUM_SIG];
    int m_port [NUM_SIG];
    logic [15:0] m_rd;

    always #5 clk = ~clk;

    strobe_port_router #(
        .NUM_SIG(NUM_SIG), .NUM_PORTS(NUM_PORTS), .CHB_BASE(CHB_BASE)
    ) i_strobe_port_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .single_chan(single_chan),
        .strobe_in(strobe_in), .strobe_out(strobe_out)
    );

    function automatic logic [NUM_PORTS-1:0] model_out(logic [NUM_SIG-1:0] s, logic sc);
        logic [NUM_PORTS-1:0] r = '0;
        for (int i = 0; i < NUM_SIG; i++)
            if (m_en[i] && s[i] && !(sc && i >= CHB_BASE)) r[m_port[i]] = 1'b1;
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(int sel, bit en, int port, logic [1:0] be);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_be   = be;
        wr_data = {1'b0, 7'(sel), 3'b101, en, 2'b10, 2'(port)} & 16'h7F13
                | 16'h0000 | ({16'h0} ) ;
        wr_data[7:5] = 3'b111;  // don't-care bits, must be ignored (R2)
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_be = 2'b00;
        if (be == 2'b11 && sel < NUM_SIG) begin
            m_en[sel]   = en;
            m_port[sel] = port;
            m_rd        = {1'b0, 7'(sel), 3'b000, en, 2'b00, 2'(port)};
        end
    endtask

    task automatic drive_check(logic [NUM_SIG-1:0] s, string req);
        strobe_in = s;
        @(posedge clk);
        @(negedge clk);
        check(req, 16'(strobe_out), 16'(model_out(s, single_chan)));
    endtask

    task automatic t_reset();
        check("R1 ports", 16'(strobe_out), 16'h0);
        check("R1 readback", rd_data, 16'h0);
        drive_check('1, "R6 all disabled");
    endtask

    task automatic t_route();
        cfg_write(3, 1'b1, 2, 2'b11);
        check("R11 readback", rd_data, m_rd);
        drive_check(NUM_SIG'(1) << 3, "R4 single route");
        check("R4 port2 only", 16'(strobe_out), 16'h0004);
    endtask

    task automatic t_or();
        cfg_write(5, 1'b1, 1, 2'b11);
        cfg_write(7, 1'b1, 1, 2'b11);
        drive_check(NUM_SIG'(1) << 5, "R5 first of pair");
        drive_check(NUM_SIG'(1) << 7, "R5 second of pair");
        drive_check((NUM_SIG'(1) << 5) | (NUM_SIG'(1) << 7), "R5 both");
        check("R5 port1", 16'(strobe_out), 16'h0002);
    endtask

    task automatic t_replace();
        cfg_write(3, 1'b1, 0, 2'b11);
        drive_check(NUM_SIG'(1) << 3, "R3 moved route");
        check("R3 old port freed", 16'(strobe_out), 16'h0001);
        drive_check(NUM_SIG'(1) << 5, "R3 neighbour kept");
    endtask

    task automatic t_latency();
        strobe_in = '0;
        @(posedge clk); @(negedge clk);
        strobe_in = NUM_SIG'(1) << 3;
        #2;
        check("R7 not before edge", 16'(strobe_out), 16'h0);
        @(posedge clk); @(negedge clk);
        check("R7 after one edge", 16'(strobe_out), 16'h0001);
        // config write effect: enable 9 on port 3 while 9 is high
        strobe_in = NUM_SIG'(1) << 9;
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b11; wr_data = {1'b0, 7'd9, 3'b000, 1'b1, 2'b00, 2'd3};
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
        m_en[9] = 1'b1; m_port[9] = 3; m_rd = {1'b0, 7'd9, 3'b000, 1'b1, 2'b00, 2'd3};
        check("R7 config not same edge", 16'(strobe_out), 16'h0);
        @(posedge clk); @(negedge clk);
        check("R7 config next edge", 16'(strobe_out), 16'h0008);
    endtask

    task automatic t_partial();
        cfg_write(3, 1'b0, 2, 2'b01);
        cfg_write(3, 1'b0, 2, 2'b10);
        check("R8 readback kept", rd_data, m_rd);
        drive_check(NUM_SIG'(1) << 3, "R8 table kept");
        check("R8 still port0", 16'(strobe_out), 16'h0001);
    endtask

    task automatic t_range();
        cfg_write(NUM_SIG, 1'b1, 2, 2'b11);
        cfg_write(NUM_SIG + 5, 1'b1, 2, 2'b11);
        check("R9 readback kept", rd_data, m_rd);
        drive_check('1, "R9 ports unchanged");
    endtask

    task automatic t_disable();
        cfg_write(3, 1'b0, 0, 2'b11);
        drive_check(NUM_SIG'(1) << 3, "R6 disabled strobe");
        check("R6 port0 low", 16'(strobe_out), 16'h0);
    endtask

    task automatic t_single();
        cfg_write(12, 1'b1, 2, 2'b11);
        single_chan = 1'b1;
        drive_check(NUM_SIG'(1) << 12, "R10 muted");
        check("R10 muted port2", 16'(strobe_out), 16'h0);
        drive_check((NUM_SIG'(1) << 12) | (NUM_SIG'(1) << 9), "R10 low channel live");
        single_chan = 1'b0;
        drive_check(NUM_SIG'(1) << 12, "R10 unmuted");
        check("R10 port2 high", 16'(strobe_out), 16'h0004);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < NUM_SIG; i++) cfg_write(i, (i % 3) != 0, i % NUM_PORTS, 2'b11);
        for (int k = 0; k < 60; k++) begin
            single_chan = (k % 4) == 0;
            drive_check(NUM_SIG'($urandom), "R5 R7 sweep");
        end
        single_chan = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NUM_SIG; i++) begin m_en[i] = 1'b0; m_port[i] = 0; end
        m_rd = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_be = 2'b00; wr_data = '0;
        single_chan = 1'b0; strobe_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", 16'(strobe_out), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_or();
        t_replace();
        t_latency();
        t_partial();
        t_range();
        t_disable();
        t_single();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule